// File: doc/BRIEF.md
# CEC Receive Bit-Period Error Checker

This block watches the single-wire consumer-electronics control bus while a frame is being received. It brings the raw bus level through a synchronizer, finds falling edges on a sampling tick, and counts the ticks between the falling edges of consecutive bits. If a bit arrives too early, or no new bit arrives before the upper bound, it reports a cycle error. The bounds sit near 2.05 ms and 2.75 ms, and each can be trimmed a few sampling ticks either way.

A reported error sets a sticky status bit and pulses a frame-abort strobe, which tells the frame assembler to drop the partial frame. The block then goes idle until the start-bit detector signals a new frame. An error caused by a bit that came too early also drives the bus low for about 3.6 ms, so that every node on the bus sees the fault. Two more receive faults, buffer overrun and waveform error, are detected outside the block and handed in as event pulses. When quiet mode is set, a late bit, an overrun or a waveform fault is not reported. Reception goes on and the frame is answered with an inverted acknowledge.

Top module: `cec_rx_period_check`

## Requirements
- R1: The raw bus input passes through a two-stage synchronizer. A falling edge counts only on a cycle with `samp_tick` high, when the synchronized level is 0 and the level seen on the previous tick was 1.
- R2: The lower bound is `TICKS_PER_MS*205/100` and the upper bound is `TICKS_PER_MS*275/100`, both in ticks. Each bound has its own 3-bit two's-complement trim (-4..+3) added to it: `cfg_min_trim` moves the lower bound and `cfg_max_trim` moves the upper bound.
- R3: While receiving, the interval of a falling edge is the number of ticks since the previous edge, or since `start_seen`, including the current tick. If that interval is below the lower bound, the block sets `stat_o[0]`, pulses `frame_abort_o` and starts driving the bus low. The quiet option never suppresses this error.
- R4: While receiving, the tick on which the interval would exceed the upper bound counts as a late-bit error, whether or not an edge arrives on it. Without quiet mode, this sets `stat_o[1]`, pulses `frame_abort_o` and returns the block to idle.
- R5: After an early-bit error, `drive_low_o` stays high for `TICKS_PER_MS*36/10` ticks and then falls, leaving the block idle. While the bus is being driven low, `start_seen` is ignored.
- R6: `receiving_o` rises only on the cycle after a `start_seen` pulse in idle. It falls after a reported error or after `frame_done`. `frame_abort_o` is a single-cycle strobe that appears only with a reported error.
- R7: With `cfg_suppress` high, a late-bit error, an overrun event or a waveform event sets no status bit and does not abort the frame, and reception continues. Such an error sets `ack_invert_o`, which stays high until the next accepted `start_seen`. A suppressed late-bit error restarts the interval count.
- R8: `overrun_evt` sets `stat_o[2]` and `wave_evt` sets `stat_o[3]`, each with an abort, but only while receiving. In any other state both events have no effect.
- R9: Status bits stay set until the matching bit of `stat_clr` is pulsed. A new error arriving in the same cycle as the clear wins, and the bit stays set.
- R10: `irq_o` is high exactly when some status bit is set whose `irq_mask` bit is also 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| samp_tick | input | 1 | Sampling strobe, one clock wide |
| bus_raw | input | 1 | Unsynchronized bus level |
| start_seen | input | 1 | Start bit recognized; measurement begins |
| frame_done | input | 1 | Frame complete; stop measuring |
| overrun_evt | input | 1 | Receive buffer overrun event |
| wave_evt | input | 1 | Waveform fault event |
| cfg_min_trim | input | 3 | Signed trim of the lower bound |
| cfg_max_trim | input | 3 | Signed trim of the upper bound |
| cfg_suppress | input | 1 | Quiet mode for late-bit, overrun and waveform faults |
| irq_mask | input | 4 | Per-status interrupt enable |
| stat_clr | input | 4 | Write-one-to-clear pulse for status bits |
| stat_o | output | 4 | Sticky status {wave, overrun, late, early} |
| irq_o | output | 1 | Error interrupt |
| drive_low_o | output | 1 | Request to pull the bus low (open-drain) |
| frame_abort_o | output | 1 | Discard-frame strobe |
| ack_invert_o | output | 1 | Answer the current frame with an inverted acknowledge |
| receiving_o | output | 1 | Measurement active |

## Verification
A wrong interval count or a misplaced bound moves the cycle on which `stat_o` and `frame_abort_o` change by at least one tick, so the reference model's comparison on every clock sees it within four clocks of the edge concerned. A corrupted state register appears at once on `receiving_o` or `drive_low_o`. A miscounted low-drive timer shows when `drive_low_o` falls at the wrong tick. A quiet-mode fault shows up as status set against `ack_invert_o` on the edge right after the offending tick.

// File: rtl/cec_chk_pkg.sv
package cec_chk_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_RX    = 2'd1,
      ST_DRIVE = 2'd2
   } rx_state_t;

   localparam int ERR_EARLY = 0;
   localparam int ERR_LATE  = 1;
   localparam int ERR_OVR   = 2;
   localparam int ERR_WAVE  = 3;
   localparam int NUM_ERR   = 4;

   function automatic int nominal_ticks(input int ticks_per_ms, input int num, input int den);
      return (ticks_per_ms * num) / den;
   endfunction
endpackage

// File: rtl/cec_bus_sync.sv
module cec_bus_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic samp_tick,
   input  logic bus_raw,
   output logic fall_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("cec_bus_sync needs at least two stages");
   end

   logic [STAGES-1:0] chain_q;
   logic              lvl_q;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) chain_q[0] <= 1'b1;
            else        chain_q[0] <= bus_raw;
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) chain_q[s] <= 1'b1;
            else        chain_q[s] <= chain_q[s-1];
      end
   end

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)         lvl_q <= 1'b1;
      else if (samp_tick) lvl_q <= chain_q[STAGES-1];

   assign fall_o = samp_tick & lvl_q & ~chain_q[STAGES-1];
endmodule

// File: rtl/cec_period_limits.sv
module cec_period_limits #(
   parameter int TICKS_PER_MS = 40,
   parameter bit TRIM_EN      = 1'b1,
   parameter int CW           = 9
) (
   input  logic [2:0]    min_trim,
   input  logic [2:0]    max_trim,
   output logic [CW-1:0] min_lim,
   output logic [CW-1:0] max_lim
);
   import cec_chk_pkg::*;

   localparam int MIN_NOM = nominal_ticks(TICKS_PER_MS, 205, 100);
   localparam int MAX_NOM = nominal_ticks(TICKS_PER_MS, 275, 100);

   if (MIN_NOM < 8 || MAX_NOM + 4 >= (1 << CW)) begin : g_bad_range
      $error("cec_period_limits: bounds do not fit the counter");
   end

   if (TRIM_EN) begin : g_trim
      always_comb begin
         min_lim = CW'(MIN_NOM) + {{(CW-3){min_trim[2]}}, min_trim};
         max_lim = CW'(MAX_NOM) + {{(CW-3){max_trim[2]}}, max_trim};
      end
   end else begin : g_fixed
      logic unused_trim;
      assign unused_trim = ^{min_trim, max_trim};
      assign min_lim = CW'(MIN_NOM);
      assign max_lim = CW'(MAX_NOM);
   end
endmodule

// File: rtl/cec_rx_period_check.sv
module cec_rx_period_check #(
   parameter int TICKS_PER_MS = 40,
   parameter int SYNC_STAGES  = 2,
   parameter bit TRIM_EN      = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       samp_tick,
   input  logic       bus_raw,
   input  logic       start_seen,
   input  logic       frame_done,
   input  logic       overrun_evt,
   input  logic       wave_evt,
   input  logic [2:0] cfg_min_trim,
   input  logic [2:0] cfg_max_trim,
   input  logic       cfg_suppress,
   input  logic [3:0] irq_mask,
   input  logic [3:0] stat_clr,
   output logic [3:0] stat_o,
   output logic       irq_o,
   output logic       drive_low_o,
   output logic       frame_abort_o,
   output logic       ack_invert_o,
   output logic       receiving_o
);
   import cec_chk_pkg::*;

   localparam int MAX_NOM  = nominal_ticks(TICKS_PER_MS, 275, 100);
   localparam int LOW_TCKS = nominal_ticks(TICKS_PER_MS, 36, 10);
   localparam int TOP_VAL  = ((LOW_TCKS > MAX_NOM + 3) ? LOW_TCKS : MAX_NOM + 3) + 2;
   localparam int CW       = $clog2(TOP_VAL) + 1;

   if (TICKS_PER_MS < 8) begin : g_bad_rate
      $error("cec_rx_period_check: TICKS_PER_MS too small");
   end

   rx_state_t         state_q;
   logic [CW-1:0]     cnt_q, nxt;
   logic [CW-1:0]     min_lim, max_lim;
   logic              fall;
   logic [NUM_ERR-1:0] stat_q, set_vec;
   logic              abort_q, ack_q;
   logic              in_rx, late_hit, early_hit, quiet, abort;

   cec_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .samp_tick (samp_tick),
      .bus_raw   (bus_raw),
      .fall_o    (fall)
   );

   cec_period_limits #(.TICKS_PER_MS(TICKS_PER_MS), .TRIM_EN(TRIM_EN), .CW(CW)) u_lim (
      .min_trim (cfg_min_trim),
      .max_trim (cfg_max_trim),
      .min_lim  (min_lim),
      .max_lim  (max_lim)
   );

   always_comb begin
      nxt       = cnt_q + 1'b1;
      in_rx     = (state_q == ST_RX);
      late_hit  = in_rx & samp_tick & (nxt > max_lim);
      early_hit = in_rx & samp_tick & ~late_hit & fall & (nxt < min_lim);
      set_vec   = '0;
      set_vec[ERR_EARLY] = early_hit;
      set_vec[ERR_LATE]  = late_hit & ~cfg_suppress;
      set_vec[ERR_OVR]   = in_rx & overrun_evt & ~cfg_suppress;
      set_vec[ERR_WAVE]  = in_rx & wave_evt & ~cfg_suppress;
      abort     = |set_vec;
      quiet     = cfg_suppress & (late_hit | (in_rx & (overrun_evt | wave_evt)));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
         ack_q   <= 1'b0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (start_seen) begin
                  state_q <= ST_RX;
                  cnt_q   <= '0;
                  ack_q   <= 1'b0;
               end
            end
            ST_RX: begin
               if (early_hit) begin
                  state_q <= ST_DRIVE;
                  cnt_q   <= '0;
               end else if (abort || frame_done) begin
                  state_q <= ST_IDLE;
               end else if (samp_tick) begin
                  cnt_q <= (fall || late_hit) ? '0 : nxt;
               end
               if (quiet && !abort) ack_q <= 1'b1;
            end
            ST_DRIVE: begin
               if (samp_tick) begin
                  if (nxt >= CW'(LOW_TCKS)) begin
                     state_q <= ST_IDLE;
                     cnt_q   <= '0;
                  end else begin
                     cnt_q <= nxt;
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat_q  <= '0;
         abort_q <= 1'b0;
      end else begin
         stat_q  <= (stat_q & ~stat_clr) | set_vec;
         abort_q <= abort;
      end
   end

   assign stat_o        = stat_q;
   assign irq_o         = |(stat_q & irq_mask);
   assign drive_low_o   = (state_q == ST_DRIVE);
   assign receiving_o   = (state_q == ST_RX);
   assign frame_abort_o = abort_q;
   assign ack_invert_o  = ack_q;
endmodule

// File: rtl/cec_rx_period_check_sva.sv
module cec_rx_period_check_sva (
   input logic       clk,
   input logic       rst_n,
   input logic       start_seen,
   input logic       cfg_suppress,
   input logic [3:0] stat_clr,
   input logic [3:0] stat_o,
   input logic       drive_low_o,
   input logic       frame_abort_o,
   input logic       ack_invert_o,
   input logic       receiving_o
);
   // R3
   early_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stat_o[0]) |-> drive_low_o);

   // R5
   drive_from_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(drive_low_o) |-> frame_abort_o);

   // R6
   abort_leaves_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_abort_o |-> !receiving_o);

   // R6
   rx_needs_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(receiving_o) |-> $past(start_seen));

   // R7
   quiet_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ack_invert_o) |-> ($past(cfg_suppress) && receiving_o));

   for (genvar k = 0; k < 4; k++) begin : g_sticky
      // R9
      sticky_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(stat_o[k]) |-> $past(stat_clr[k]));
   end
endmodule

bind cec_rx_period_check cec_rx_period_check_sva u_sva (
   .clk           (clk),
   .rst_n         (rst_n),
   .start_seen    (start_seen),
   .cfg_suppress  (cfg_suppress),
   .stat_clr      (stat_clr),
   .stat_o        (stat_o),
   .drive_low_o   (drive_low_o),
   .frame_abort_o (frame_abort_o),
   .ack_invert_o  (ack_invert_o),
   .receiving_o   (receiving_o)
);

// File: tb/cec_rx_period_check_test.sv
`timescale 1ns/1ps
module cec_rx_period_check_test;
   localparam int TPM  = 20;
   localparam int MINN = TPM * 205 / 100;
   localparam int MAXN = TPM * 275 / 100;
   localparam int LOWT = TPM * 36 / 10;
   localparam int TDIV = 4;

   logic clk = 0, rst_n = 0;
   logic bus_raw = 1, start_seen = 0, frame_done = 0, overrun_evt = 0, wave_evt = 0;
   logic [2:0] cfg_min_trim = 0, cfg_max_trim = 0;
   logic cfg_suppress = 0;
   logic [3:0] irq_mask = 4'hF, stat_clr = 0;
   logic [3:0] stat_o;
   logic irq_o, drive_low_o, frame_abort_o, ack_invert_o, receiving_o;
   int divcnt = 0;
   logic samp_tick;
   int n_checks = 0, n_fail = 0, cycles = 0;
   bit finished = 0;

   always #2.5 clk = ~clk;
   assign samp_tick = (divcnt == 0);
   always @(posedge clk) divcnt <= (divcnt == TDIV - 1) ? 0 : divcnt + 1;

   cec_rx_period_check #(.TICKS_PER_MS(TPM)) uut (
      .clk(clk), .rst_n(rst_n), .samp_tick(samp_tick), .bus_raw(bus_raw),
      .start_seen(start_seen), .frame_done(frame_done), .overrun_evt(overrun_evt),
      .wave_evt(wave_evt), .cfg_min_trim(cfg_min_trim), .cfg_max_trim(cfg_max_trim),
      .cfg_suppress(cfg_suppress), .irq_mask(irq_mask), .stat_clr(stat_clr),
      .stat_o(stat_o), .irq_o(irq_o), .drive_low_o(drive_low_o),
      .frame_abort_o(frame_abort_o), .ack_invert_o(ack_invert_o), .receiving_o(receiving_o)
   );

   // behavioural reference model
   int m_s1, m_s2, m_lvl, m_state, m_cnt, m_stat, m_abort, m_ack;
   always @(posedge clk) begin
      int mn, mx, set, iv;
      bit fall, lateh, earlyh, quiet, ab;
      if (!rst_n) begin
         m_s1 = 1; m_s2 = 1; m_lvl = 1; m_state = 0; m_cnt = 0;
         m_stat = 0; m_abort = 0; m_ack = 0;
      end else begin
         mn = MINN + $signed(cfg_min_trim);
         mx = MAXN + $signed(cfg_max_trim);
         fall = samp_tick && (m_lvl == 1) && (m_s2 == 0);
         if (samp_tick) m_lvl = m_s2;
         m_s2 = m_s1; m_s1 = bus_raw;
         set = 0; ab = 0; iv = m_cnt + 1;
         if (m_state == 1) begin
            lateh  = samp_tick && iv > mx;
            earlyh = samp_tick && !lateh && fall && iv < mn;
            if (earlyh) set |= 1;
            if (lateh && !cfg_suppress) set |= 2;
            if (overrun_evt && !cfg_suppress) set |= 4;
            if (wave_evt && !cfg_suppress) set |= 8;
            ab = (set != 0);
            quiet = cfg_suppress && (lateh || overrun_evt || wave_evt);
            if (quiet && !ab) m_ack = 1;
            if (earlyh) begin m_state = 2; m_cnt = 0; end
            else if (ab || frame_done) m_state = 0;
            else if (samp_tick) m_cnt = (fall || lateh) ? 0 : iv;
         end else if (m_state == 0) begin
            if (start_seen) begin m_state = 1; m_cnt = 0; m_ack = 0; end
         end else if (samp_tick) begin
            if (iv >= LOWT) begin m_state = 0; m_cnt = 0; end
            else m_cnt = iv;
         end
         m_stat = (m_stat & ~int'(stat_clr)) | set;
         m_abort = ab;
      end
   end

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !finished) begin
         check(stat_o[0] == m_stat[0], "R3 early status", stat_o[0], m_stat[0]);
         check(stat_o[1] == m_stat[1], "R4 late status", stat_o[1], m_stat[1]);
         check(stat_o[3:2] == m_stat[3:2], "R8 event status", stat_o[3:2], m_stat[3:2]);
         check(drive_low_o == (m_state == 2), "R5 drive low", drive_low_o, m_state == 2);
         check(receiving_o == (m_state == 1), "R6 receiving", receiving_o, m_state == 1);
         check(frame_abort_o == m_abort[0], "R6 abort strobe", frame_abort_o, m_abort);
         check(ack_invert_o == m_ack[0], "R7 ack invert", ack_invert_o, m_ack);
         check(irq_o == |(m_stat[3:0] & irq_mask), "R10 irq", irq_o, |(m_stat[3:0] & irq_mask));
      end
   end

   task automatic wait_ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         while (!samp_tick) @(negedge clk);
         @(negedge clk);
      end
   endtask
   task automatic pulse_start;  start_seen = 1;  @(negedge clk); start_seen = 0;  endtask
   task automatic pulse_done;   frame_done = 1;  @(negedge clk); frame_done = 0;  endtask
   task automatic pulse_ovr;    overrun_evt = 1; @(negedge clk); overrun_evt = 0; endtask
   task automatic pulse_wave;   wave_evt = 1;    @(negedge clk); wave_evt = 0;    endtask
   task automatic clear_all;    stat_clr = 4'hF; @(negedge clk); stat_clr = 0;    endtask
   task automatic start_frame;  bus_raw = 0; wait_ticks(1); pulse_start(); endtask
   task automatic bitw(input int n);
      wait_ticks(8); bus_raw = 1; wait_ticks(n - 8); bus_raw = 0;
   endtask
   task automatic end_frame;    wait_ticks(8); bus_raw = 1; wait_ticks(4); pulse_done(); endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (6) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      check(stat_o == 0 && !irq_o && !drive_low_o && !receiving_o && !ack_invert_o,
            "R6 reset state", {stat_o, drive_low_o, receiving_o}, 0);

      // R8: events ignored while idle
      pulse_ovr(); pulse_wave(); wait_ticks(2);
      check(stat_o == 0, "R8 idle events ignored", stat_o, 0);

      // R1 R2: valid frame at nominal bounds
      start_frame(); bitw(48); bitw(48); bitw(48); end_frame();
      check(stat_o == 0, "R1 valid bits", stat_o, 0);
      check(!receiving_o, "R6 frame done", receiving_o, 0);

      // R3 R5: early bit
      wait_ticks(20); start_frame(); bitw(30); wait_ticks(3);
      check(stat_o[0] && drive_low_o, "R3 early bit", {stat_o[0], drive_low_o}, 3);
      pulse_start();
      wait_ticks(10);
      check(drive_low_o && !receiving_o, "R5 start ignored while driving", receiving_o, 0);
      wait_ticks(LOWT);
      bus_raw = 1;
      check(!drive_low_o && !receiving_o, "R5 drive ends", {drive_low_o, receiving_o}, 0);

      // R9 + R10
      irq_mask = 4'h2; @(negedge clk);
      check(!irq_o, "R10 masked irq", irq_o, 0);
      irq_mask = 4'h1; @(negedge clk);
      check(irq_o, "R10 unmasked irq", irq_o, 1);
      irq_mask = 4'hF;
      wait_ticks(5);
      check(stat_o[0], "R9 sticky", stat_o[0], 1);
      clear_all();
      check(stat_o == 0, "R9 clear", stat_o, 0);

      // R2: min trim +3 makes 42 early
      cfg_min_trim = 3'd3; wait_ticks(10);
      start_frame(); bitw(48); bitw(42); wait_ticks(3);
      check(stat_o[0], "R2 min trim up", stat_o[0], 1);
      wait_ticks(LOWT + 4); bus_raw = 1; clear_all();
      // R2: min trim -4 accepts 40
      cfg_min_trim = 3'b100; wait_ticks(10);
      start_frame(); bitw(48); bitw(40); end_frame();
      check(stat_o == 0, "R2 min trim down", stat_o, 0);
      cfg_min_trim = 0;

      // R4: stalled bus
      wait_ticks(10); start_frame(); bitw(48); wait_ticks(8); bus_raw = 1; wait_ticks(70);
      check(stat_o[1] && !receiving_o, "R4 late bit", {stat_o[1], receiving_o}, 2);
      clear_all();
      // R2: max trim -4 flags 53
      cfg_max_trim = 3'b100; wait_ticks(10);
      start_frame(); bitw(48); bitw(53); wait_ticks(3);
      check(stat_o[1], "R2 max trim down", stat_o[1], 1);
      bus_raw = 1; cfg_max_trim = 0; wait_ticks(10); clear_all();

      // R7: quiet mode
      cfg_suppress = 1; wait_ticks(5);
      start_frame(); bitw(48); wait_ticks(8); bus_raw = 1; wait_ticks(52);
      check(ack_invert_o && receiving_o && stat_o == 0, "R7 quiet late",
            {ack_invert_o, receiving_o, stat_o}, 6'b110000);
      pulse_ovr(); pulse_wave(); @(negedge clk);
      check(receiving_o && stat_o == 0, "R7 quiet events", stat_o, 0);
      pulse_done(); wait_ticks(3);
      start_frame(); @(negedge clk);
      check(!ack_invert_o, "R7 ack cleared on start", ack_invert_o, 0);
      bitw(30); wait_ticks(3);
      check(stat_o[0], "R7 early not suppressed", stat_o[0], 1);
      wait_ticks(LOWT + 4); bus_raw = 1; cfg_suppress = 0; clear_all();

      // R8: events while receiving
      wait_ticks(5); start_frame(); wait_ticks(3); pulse_ovr(); @(negedge clk);
      check(stat_o[2] && !receiving_o, "R8 overrun", stat_o, 4);
      wait_ticks(3); start_frame(); wait_ticks(3); pulse_wave(); @(negedge clk);
      check(stat_o[3], "R8 waveform", stat_o, 12);
      bus_raw = 1;

      // R9: set wins over clear
      wait_ticks(5); start_frame(); wait_ticks(3);
      stat_clr = 4'h4; overrun_evt = 1; @(negedge clk); stat_clr = 0; overrun_evt = 0;
      check(stat_o[2], "R9 set beats clear", stat_o[2], 1);
      bus_raw = 1; wait_ticks(5);

      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end
endmodule